// File: doc/BRIEF.md
# Posted-Write Watchdog Timer

A watchdog peripheral split across two clocks. A fast bus clock hosts a small register window. A slow timebase clock, nominally 32 kHz, runs an up-counter. When the up-counter wraps from all ones to zero, the block raises a reset request for a single bus cycle. It then reloads the counter and keeps running.

Every register write is posted. The bus side holds the written value and flips a request toggle. The slow side picks the value up a few slow cycles later. A per-register pending bit in a status word shows when a write is still in flight.

Software configures the timer while it is stopped: it sets the prescaler and the reload value, then arms the timer with a two-write key sequence. To keep the timer quiet, software writes a trigger value that differs from the previous one, which restarts the count. A second key sequence stops the timer.

Top module: `wdt_posted_top`

## Requirements
- R1: After reset the load register reads 0xFFFB0000 and the control register reads 0. The status register reads 0, the timer is stopped, and no reset request is raised.
- R2: Register offsets are control 0x00, load 0x04, trigger 0x08, key 0x0C and status 0x10. Control bit 0 enables the prescaler and control bits [3:1] hold the ratio exponent. Reading control, load, trigger or key returns the last value the bus side accepted.
- R3: Status bits are assigned as follows: bit 0 is control, bit 1 is load, bit 2 is trigger and bit 3 is key. A bit is set from the cycle after an accepted write until that write has reached the slow domain. With nothing in flight, status reads 0.
- R4: A write to a register whose pending bit is set is dropped, and the held value is unchanged.
- R5: The timer starts counting only after key writes of 0xBBBB and then 0x4444.
- R6: The timer stops only after key writes of 0xAAAA and then 0x5555.
- R7: A key write other than the expected second value cancels a partial sequence and leaves the run state unchanged. A lone second value has no effect.
- R8: While running, the counter steps up once per tick. On the wrap from 0xFFFFFFFF, the counter reloads from the load register and a one-bus-cycle reset request is issued. Consecutive requests are therefore (2^32 − load) ticks apart.
- R9: With the prescaler enabled, one tick occurs every 2^ratio slow cycles. With it disabled, every slow cycle is a tick.
- R10: Control and load writes that arrive in the slow domain while the timer runs are discarded. Their pending bits still clear.
- R11: A trigger write whose value differs from the previous trigger value reloads the counter from the load register and clears the prescaler.
- R12: A trigger write equal to the previous trigger value does not reload the counter.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| bclk | input | 1 | Bus clock |
| sclk | input | 1 | Slow timebase clock |
| rst_n | input | 1 | Synchronous active-low reset, held across several slow edges |
| bus_wr | input | 1 | Write strobe, one bus cycle per write |
| bus_addr | input | 5 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| rst_req | output | 1 | One-bus-cycle system reset request |

## Verification
The bench uses a slow clock that is an exact integer fraction of the bus clock. This makes the spacing between reset requests exact: it distinguishes a 16-tick load from a 32-tick load, and a prescale ratio of 4 from 1. The timer is first run with the prescaler off and a short load, then with the prescaler on and a different load. Each run shows whether the reload value and the tick divider in force are the configured ones or the values discarded during the run.

Key streams cover four cases:
- a clean arm;
- an arm interrupted by a stray value;
- a lone second value;
- a disarm interrupted while running.

Together these separate a real sequence detector from one that reacts to single values. The trigger is exercised with alternating values spaced well inside the timeout, which must suppress every request. A repeated value late in the window must let the request through early. This tells reload-on-change apart from reload-on-any-write.

// File: rtl/wdt_pkg.sv
// Shared constants and types for the posted-write watchdog.
package wdt_pkg;
    localparam int DW       = 32;
    localparam int NCH      = 4;     // posted channels
    localparam int CH_CTRL  = 0;
    localparam int CH_LOAD  = 1;
    localparam int CH_TRIG  = 2;
    localparam int CH_KEY   = 3;
    localparam int OFS_STAT = 16;

    localparam logic [DW-1:0] KEY_ARM_A = 32'h0000_BBBB;
    localparam logic [DW-1:0] KEY_ARM_B = 32'h0000_4444;
    localparam logic [DW-1:0] KEY_DIS_A = 32'h0000_AAAA;
    localparam logic [DW-1:0] KEY_DIS_B = 32'h0000_5555;

    typedef enum logic [1:0] {KS_IDLE, KS_ARM, KS_DIS} key_state_e;

    // Byte offset of a posted channel in the register window.
    function automatic int ch_ofs(int ch);
        return ch * 4;
    endfunction
endpackage

// File: rtl/wdt_post_chan.sv
// One posted-write channel. The bus side holds the data and flips a request
// toggle. The slow side detects the flip and emits a one-cycle strobe, then
// returns an acknowledge toggle.
// Assumes: hold is stable while pending, so the slow side may sample it.
module wdt_post_chan #(
    parameter int              W       = 32,
    parameter logic [W-1:0]    RST_VAL = '0
) (
    input  logic         bclk,
    input  logic         sclk,
    input  logic         rst_n,
    input  logic         wr,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] hold,
    output logic         pend,
    output logic         s_stb
);
    logic req_t, ack_b1, ack_b2;
    logic req_s1, req_s2, req_s3, ack_t;

    assign pend  = req_t ^ ack_b2;
    assign s_stb = req_s2 ^ req_s3;

    // Bus side: accept a write only when nothing is in flight.
    always_ff @(posedge bclk) begin
        if (!rst_n) begin
            hold  <= RST_VAL;
            req_t <= 1'b0;
        end else if (wr && !pend) begin
            hold  <= wdata;
            req_t <= ~req_t;
        end
    end

    // Bus side: bring the acknowledge toggle in through two flops.
    always_ff @(posedge bclk) begin
        if (!rst_n) begin
            ack_b1 <= 1'b0;
            ack_b2 <= 1'b0;
        end else begin
            ack_b1 <= ack_t;
            ack_b2 <= ack_b1;
        end
    end

    // Slow side: synchronise the request and return the acknowledge.
    always_ff @(posedge sclk) begin
        if (!rst_n) begin
            req_s1 <= 1'b0;
            req_s2 <= 1'b0;
            req_s3 <= 1'b0;
            ack_t  <= 1'b0;
        end else begin
            req_s1 <= req_t;
            req_s2 <= req_s1;
            req_s3 <= req_s2;
            ack_t  <= req_s2;
        end
    end

    AST_WR_SETS_PEND: assert property (@(posedge bclk) disable iff (!rst_n)
        wr && !pend |=> pend);                       // R3
    AST_DROP_WHILE_PEND: assert property (@(posedge bclk) disable iff (!rst_n)
        wr && pend |=> $stable(hold));               // R4
endmodule

// File: rtl/wdt_core.sv
// Slow-domain timer core. It holds the key sequencer, the frozen
// configuration, the trigger compare, the prescaler and the up-counter.
// Overflows leave as a toggle for the bus side to pick up.
// Assumes: strobes are one sclk cycle and their data is stable meanwhile.
module wdt_core
    import wdt_pkg::*;
#(
    parameter int              CNT_W    = 32,
    parameter int              PTV_W    = 3,
    parameter logic [CNT_W-1:0] LOAD_RST = 32'hFFFB_0000
) (
    input  logic              sclk,
    input  logic              rst_n,
    input  logic              ctrl_stb,
    input  logic [PTV_W:0]    ctrl_data,
    input  logic              load_stb,
    input  logic [CNT_W-1:0]  load_data,
    input  logic              trig_stb,
    input  logic [DW-1:0]     trig_data,
    input  logic              key_stb,
    input  logic [DW-1:0]     key_data,
    output logic              ovf_tgl
);
    localparam int PRE_W = (1 << PTV_W) - 1;

    logic [PTV_W:0]     ctrl_q;
    logic [CNT_W-1:0]   load_q, cnt_q;
    logic [DW-1:0]      trig_last;
    logic [PRE_W-1:0]   pre_q, pre_mask;
    key_state_e         key_q, key_nx;
    logic               run_q, run_nx, tick, reload;

    // Configuration is accepted only while the timer is stopped.
    always_ff @(posedge sclk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            load_q <= LOAD_RST;
        end else if (!run_q) begin
            if (ctrl_stb) ctrl_q <= ctrl_data;
            if (load_stb) load_q <= load_data;
        end
    end

    // Key sequence decoder: next state and next run flag.
    always_comb begin
        key_nx = key_q;
        run_nx = run_q;
        if (key_stb) begin
            key_nx = KS_IDLE;
            if (key_data == KEY_ARM_A)                         key_nx = KS_ARM;
            else if (key_data == KEY_DIS_A)                    key_nx = KS_DIS;
            else if (key_q == KS_ARM && key_data == KEY_ARM_B) run_nx = 1'b1;
            else if (key_q == KS_DIS && key_data == KEY_DIS_B) run_nx = 1'b0;
        end
    end

    // Key sequence state register.
    always_ff @(posedge sclk) begin
        if (!rst_n) begin
            key_q <= KS_IDLE;
            run_q <= 1'b0;
        end else begin
            key_q <= key_nx;
            run_q <= run_nx;
        end
    end

    // Tick generation from the prescaler exponent.
    always_comb begin
        pre_mask = PRE_W'((PRE_W+1)'(1) << ctrl_q[PTV_W:1]) - PRE_W'(1);
        tick     = !ctrl_q[0] || ((pre_q & pre_mask) == pre_mask);
        reload   = trig_stb && (trig_data != trig_last);
    end

    // Counter, prescaler, trigger memory and overflow toggle.
    always_ff @(posedge sclk) begin
        if (!rst_n) begin
            cnt_q     <= LOAD_RST;
            pre_q     <= '0;
            trig_last <= '0;
            ovf_tgl   <= 1'b0;
        end else begin
            if (trig_stb) trig_last <= trig_data;
            if (reload) begin
                cnt_q <= load_q;
                pre_q <= '0;
            end else if (run_q) begin
                pre_q <= pre_q + PRE_W'(1);
                if (tick) begin
                    if (&cnt_q) begin
                        cnt_q   <= load_q;
                        ovf_tgl <= ~ovf_tgl;
                    end else begin
                        cnt_q <= cnt_q + CNT_W'(1);
                    end
                end
            end
        end
    end

    AST_ARM_BY_KEY: assert property (@(posedge sclk) disable iff (!rst_n)
        $rose(run_q) |-> $past(key_stb) && $past(key_data) == KEY_ARM_B
                         && $past(key_q) == KS_ARM);               // R5
    AST_DISARM_BY_KEY: assert property (@(posedge sclk) disable iff (!rst_n)
        $fell(run_q) |-> $past(key_stb) && $past(key_data) == KEY_DIS_B
                         && $past(key_q) == KS_DIS);               // R6
    AST_CFG_FROZEN: assert property (@(posedge sclk) disable iff (!rst_n)
        $past(run_q) && run_q |-> $stable(load_q) && $stable(ctrl_q)); // R10
    AST_WRAP_RELOAD: assert property (@(posedge sclk) disable iff (!rst_n)
        run_q && tick && (&cnt_q) && !reload
        |=> cnt_q == $past(load_q) && ovf_tgl != $past(ovf_tgl));  // R8
    AST_SAME_TRIG_HOLD: assert property (@(posedge sclk) disable iff (!rst_n)
        trig_stb && trig_data == trig_last && !run_q |=> $stable(cnt_q)); // R12
endmodule

// File: rtl/wdt_pulse_sync.sv
// Turns a slow-domain toggle into a single bus-cycle pulse.
// Assumes: the toggle changes no more often than every few bus cycles.
module wdt_pulse_sync (
    input  logic bclk,
    input  logic rst_n,
    input  logic tgl,
    output logic pulse
);
    logic s1, s2, s3;

    // Two-flop synchroniser, edge register and registered pulse.
    always_ff @(posedge bclk) begin
        if (!rst_n) begin
            s1    <= 1'b0;
            s2    <= 1'b0;
            s3    <= 1'b0;
            pulse <= 1'b0;
        end else begin
            s1    <= tgl;
            s2    <= s1;
            s3    <= s2;
            pulse <= s2 ^ s3;
        end
    end

    AST_REQ_ONE_CYCLE: assert property (@(posedge bclk) disable iff (!rst_n)
        pulse |=> !pulse);                           // R8
endmodule

// File: rtl/wdt_posted_top.sv
// Watchdog top: register window, four posted channels, the slow core and
// the return path for the reset request.
// Assumes: bus_addr is valid during bus_wr; reads are combinational.
module wdt_posted_top
    import wdt_pkg::*;
#(
    parameter int              AW       = 5,
    parameter int              PTV_W    = 3,
    parameter logic [DW-1:0]   LOAD_RST = 32'hFFFB_0000
) (
    input  logic          bclk,
    input  logic          sclk,
    input  logic          rst_n,
    input  logic          bus_wr,
    input  logic [AW-1:0] bus_addr,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    output logic          rst_req
);
    logic [DW-1:0]  hold [NCH];
    logic [NCH-1:0] pend, s_stb;
    logic           ovf_tgl;

    for (genvar i = 0; i < NCH; i++) begin : g_chan
        localparam logic [DW-1:0] RV = (i == CH_LOAD) ? LOAD_RST : '0;
        logic wr_i;
        assign wr_i = bus_wr && (bus_addr == AW'(ch_ofs(i)));
        wdt_post_chan #(.W(DW), .RST_VAL(RV)) u_chan (
            .bclk  (bclk),
            .sclk  (sclk),
            .rst_n (rst_n),
            .wr    (wr_i),
            .wdata (bus_wdata),
            .hold  (hold[i]),
            .pend  (pend[i]),
            .s_stb (s_stb[i])
        );
    end

    // Read mux over held values and the pending word.
    always_comb begin
        bus_rdata = '0;
        for (int i = 0; i < NCH; i++)
            if (bus_addr == AW'(ch_ofs(i))) bus_rdata = hold[i];
        if (bus_addr == AW'(OFS_STAT)) bus_rdata = DW'(pend);
    end

    wdt_core #(.CNT_W(DW), .PTV_W(PTV_W), .LOAD_RST(LOAD_RST)) u_core (
        .sclk      (sclk),
        .rst_n     (rst_n),
        .ctrl_stb  (s_stb[CH_CTRL]),
        .ctrl_data (hold[CH_CTRL][PTV_W:0]),
        .load_stb  (s_stb[CH_LOAD]),
        .load_data (hold[CH_LOAD]),
        .trig_stb  (s_stb[CH_TRIG]),
        .trig_data (hold[CH_TRIG]),
        .key_stb   (s_stb[CH_KEY]),
        .key_data  (hold[CH_KEY]),
        .ovf_tgl   (ovf_tgl)
    );

    wdt_pulse_sync u_req (
        .bclk  (bclk),
        .rst_n (rst_n),
        .tgl   (ovf_tgl),
        .pulse (rst_req)
    );

    AST_STAT_IDLE_AFTER_RESET: assert property (@(posedge bclk) disable iff (!rst_n)
        $rose(rst_n) |-> pend == '0);                // R1
endmodule

// File: tb/wdt_posted_top_tb.sv
// Bench: the slow clock is scaled to 1/8 of the 50 MHz bus clock so that
// reset-request spacing is an exact number of bus cycles.
module wdt_posted_top_tb;
    localparam int SLOW_DIV = 8;
    localparam logic [4:0] A_CTRL = 5'h00, A_LOAD = 5'h04, A_TRIG = 5'h08,
                           A_KEY = 5'h0C, A_STAT = 5'h10;

    logic bclk = 0, sclk = 0, rst_n = 0, bus_wr = 0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0, bus_rdata;
    logic rst_req;

    int n_cmp = 0, n_bad = 0, cyc = 0;
    int pulses[$];
    bit prev_req = 0, allow_pulse = 0;
    logic [31:0] trig_pat = 32'h1234;

    wdt_posted_top u_dut (.bclk(bclk), .sclk(sclk), .rst_n(rst_n), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .rst_req(rst_req));

    always #10 bclk = ~bclk;
    initial begin #5; forever #80 sclk = ~sclk; end

    task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Per-clock model compare: pulse width and whether a request may occur.
    always @(negedge bclk) begin
        cyc++;
        if (rst_n) begin
            n_cmp++;
            if (rst_req && prev_req) begin
                n_bad++; $display("FAIL R8 actual=wide_pulse expected=one_cycle");
            end else if (rst_req && !allow_pulse) begin
                n_bad++; $display("FAIL R5 actual=1 expected=0 (request while stopped)");
            end
            if (rst_req) pulses.push_back(cyc);
        end
        prev_req = rst_req;
    end

    task automatic bus_write(logic [4:0] a, logic [31:0] d);
        @(negedge bclk); bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(negedge bclk); bus_wr = 0;
    endtask

    task automatic bus_read(logic [4:0] a, output logic [31:0] v);
        @(negedge bclk); bus_addr = a; #1; v = bus_rdata;
    endtask

    task automatic wait_idle(string req);
        logic [31:0] s;
        for (int i = 0; i < 300; i++) begin
            bus_read(A_STAT, s);
            if (s == 0) return;
        end
        check(0, req, s, 0);
    endtask

    task automatic post(logic [4:0] a, logic [31:0] d);
        bus_write(a, d); wait_idle("R3");
    endtask

    task automatic measure(int exp, string req);
        pulses.delete();
        for (int i = 0; i < exp * 3 + 600 && pulses.size() < 3; i++) @(negedge bclk);
        if (pulses.size() < 3) check(0, req, pulses.size(), 3);
        else check(pulses[2] - pulses[1] == exp, req, pulses[2] - pulses[1], exp);
    endtask

    task automatic quiet(int n, string req);
        pulses.delete();
        repeat (n) @(negedge bclk);
        check(pulses.size() == 0, req, pulses.size(), 0);
    endtask

    task automatic disarm();
        post(A_KEY, 32'hAAAA); post(A_KEY, 32'h5555);
        repeat (300) @(negedge bclk);
        allow_pulse = 0;
    endtask

    initial begin
        logic [31:0] v;
        repeat (40) @(negedge bclk);
        rst_n = 1;
        // R1 / R2: reset values through the register window
        bus_read(A_CTRL, v); check(v == 0, "R1 ctrl", v, 0);
        bus_read(A_LOAD, v); check(v == 32'hFFFB0000, "R1 R2 load", v, 32'hFFFB0000);
        bus_read(A_STAT, v); check(v == 0, "R1 stat", v, 0);
        quiet(300, "R1 no request");

        // R3 / R4: pending bit and dropped write
        bus_write(A_LOAD, 32'hFFFFFFF0);
        bus_read(A_STAT, v); check(v == 32'h2, "R3 load pending", v, 2);
        bus_write(A_LOAD, 32'h11111111);
        bus_read(A_LOAD, v); check(v == 32'hFFFFFFF0, "R4 dropped", v, 32'hFFFFFFF0);
        wait_idle("R3");
        bus_read(A_STAT, v); check(v == 0, "R3 idle", v, 0);
        trig_pat = ~trig_pat; post(A_TRIG, trig_pat);
        bus_read(A_TRIG, v); check(v == trig_pat, "R2 trig read", v, trig_pat);

        // R7: broken and lone key values do not arm
        post(A_KEY, 32'hBBBB); post(A_KEY, 32'h1111); post(A_KEY, 32'h4444);
        quiet(600, "R7 broken arm");
        post(A_KEY, 32'h4444);
        quiet(600, "R7 lone second");

        // R5 / R8: arm, 16 ticks per request
        allow_pulse = 1;
        post(A_KEY, 32'hBBBB); post(A_KEY, 32'h4444);
        measure(16 * SLOW_DIV, "R5 R8 period");

        // R7: interrupted disarm keeps it running
        post(A_KEY, 32'hAAAA); post(A_KEY, 32'h1234); post(A_KEY, 32'h5555);
        measure(16 * SLOW_DIV, "R7 still running");

        // R10: configuration writes while running are discarded
        post(A_CTRL, 32'h5); post(A_LOAD, 32'hFFFFFFE0);
        measure(16 * SLOW_DIV, "R10 config ignored");
        bus_read(A_STAT, v); check(v == 0, "R10 pending cleared", v, 0);

        // R6: disarm
        disarm();
        quiet(1000, "R6 stopped");

        // R9: prescaler ratio 4, 8 ticks
        post(A_CTRL, 32'h5); post(A_LOAD, 32'hFFFFFFF8);
        trig_pat = ~trig_pat; post(A_TRIG, trig_pat);
        allow_pulse = 1;
        post(A_KEY, 32'hBBBB); post(A_KEY, 32'h4444);
        measure(8 * 4 * SLOW_DIV, "R9 prescaled period");
        disarm();

        // R11: alternating trigger values keep it quiet (256 ticks = 2048 cycles)
        post(A_CTRL, 32'h0); post(A_LOAD, 32'hFFFFFF00);
        trig_pat = ~trig_pat; post(A_TRIG, trig_pat);
        allow_pulse = 1;
        post(A_KEY, 32'hBBBB); post(A_KEY, 32'h4444);
        pulses.delete();
        for (int k = 0; k < 6; k++) begin
            repeat (700) @(negedge bclk);
            trig_pat = ~trig_pat; post(A_TRIG, trig_pat);
        end
        check(pulses.size() == 0, "R11 serviced", pulses.size(), 0);

        // R12: repeated value late in the window does not restart the count
        repeat (1300) @(negedge bclk);
        pulses.delete();
        post(A_TRIG, trig_pat);
        for (int i = 0; i < 1000 && pulses.size() == 0; i++) @(negedge bclk);
        check(pulses.size() != 0, "R12 same value no reload", pulses.size(), 1);
        disarm();

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge bclk);
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule